// File: doc/BRIEF.md
# Bit-Sliced Four-Bit ALU with Set-on-Less-Than

A purely combinational arithmetic and logic unit on two 4-bit operands. The datapath is a ripple chain of four 1-bit slices. The three low slices are identical. The top slice is a distinct variant that also produces a set line and the raw signed-overflow term. Each slice selects among AND, OR, its sum bit and a less input. Subtraction and compare invert b in every slice and force the carry into bit 0 high.

Signed set-on-less-than routes the top slice's set line back to the less input of bit 0. The less inputs of the other slices are tied low. The set line is corrected by the overflow term, so the compare stays right when a minus b overflows. Two single-operand operations on a sit beside the slice chain: arithmetic shift right by one and rotate left by one. A 3-bit code picks the operation. The Zero flag reports an all-zero result. The Overflow flag reports signed overflow for add and subtract only.

Top module: `alu_sliced`

## Requirements
- R1: Code 000 gives result = a AND b, bit by bit.
- R2: Code 001 gives result = a OR b, bit by bit.
- R3: Code 010 gives result = (a + b) modulo 16.
- R4: Code 110 gives result = (a - b) modulo 16.
- R5: Code 111 gives result 0001 when a is less than b as two's-complement signed values, else 0000, including when a - b overflows (for example -8 vs 7 gives 0001, and 7 vs -8 gives 0000).
- R6: Code 011 gives result = {a[3], a[3:1]}, an arithmetic shift right by one of a; b has no effect.
- R7: Code 100 gives result = {a[2:0], a[3]}, a rotate left by one of a; b has no effect.
- R8: Codes 101 gives result 0000 and Overflow 0.
- R9: Zero is 1 exactly when all four result bits are 0, for every code.
- R10: Overflow is 1 for codes 010 and 110 exactly when the signed result falls outside -8..7, and is 0 for all other codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Operand a, two's complement |
| b_i | input | 4 | Operand b, two's complement |
| op_i | input | 3 | Operation code |
| result_o | output | 4 | Operation result |
| zero_o | output | 1 | High when result is all zero |
| ovf_o | output | 1 | Signed overflow, add and subtract only |

## Verification
The in-line checks assume every input bit is a known 0 or 1 and that the operation code is stable while the outputs are judged. The overflow check in the top slice also assumes b is inverted only for subtract and compare. The stimulus drives only fully defined values. It holds each vector for half a clock period before the outputs are compared. It runs every one of the eight codes over all 256 operand pairs, after a set of named signed corner cases.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_ASR = 3'b011,
    OP_ROL = 3'b100,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } slice_sel_e;
endpackage

// File: rtl/alu_full_add.sv
module alu_full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ c_i;
  assign c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       binv_i,
  input  logic       carry_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       carry_o
);
  logic bx, sum;

  assign bx = b_i ^ binv_i;

  alu_full_add u_fa (.x_i(a_i), .y_i(bx), .c_i(carry_i), .s_o(sum), .c_o(carry_o));

  always_comb begin
    unique case (slice_sel_e'(sel_i))
      SEL_AND:  res_o = a_i & bx;
      SEL_OR:   res_o = a_i | bx;
      SEL_SUM:  res_o = sum;
      default:  res_o = less_i;
    endcase
  end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       binv_i,
  input  logic       carry_i,
  input  logic       less_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       carry_o,
  output logic       set_o,
  output logic       ovf_o
);
  logic bx, sum;

  assign bx = b_i ^ binv_i;

  alu_full_add u_fa (.x_i(a_i), .y_i(bx), .c_i(carry_i), .s_o(sum), .c_o(carry_o));

  assign ovf_o = carry_i ^ carry_o;
  // sign of the true difference, valid even when the 4-bit result wraps
  assign set_o = sum ^ ovf_o;

  always_comb begin
    unique case (slice_sel_e'(sel_i))
      SEL_AND:  res_o = a_i & bx;
      SEL_OR:   res_o = a_i | bx;
      SEL_SUM:  res_o = sum;
      default:  res_o = less_i;
    endcase
  end

  always_comb begin
    // R10
    ovf_sign_chk: assert (!ovf_o || ((a_i == bx) && (sum != a_i)))
      else $error("overflow raised without like-signed operands");
  end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] asr_o,
  output logic [W-1:0] rol_o
);
  assign asr_o = {a_i[W-1], a_i[W-1:1]};
  assign rol_o = {a_i[W-2:0], a_i[W-1]};
endmodule

// File: rtl/alu_sliced.sv
module alu_sliced
  import alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  alu_op_e       op;
  logic          sub_w;
  logic          arith_w;
  logic [1:0]    sel_w;
  logic          set_w;
  logic          ovf_raw;
  logic [W-1:0]  slice_res;
  logic [W-1:0]  asr_w, rol_w;

  assign op      = alu_op_e'(op_i);
  assign sub_w   = (op == OP_SUB) || (op == OP_SLT);
  assign arith_w = (op == OP_ADD) || (op == OP_SUB);

  always_comb begin
    unique case (op)
      OP_AND:  sel_w = SEL_AND;
      OP_OR:   sel_w = SEL_OR;
      OP_SLT:  sel_w = SEL_LESS;
      default: sel_w = SEL_SUM;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic c_in, c_out, r, lss;
    if (i == 0) begin : g_c0
      assign c_in = sub_w;
      assign lss  = set_w;
    end else begin : g_cn
      assign c_in = g_bit[i-1].c_out;
      assign lss  = 1'b0;
    end
    if (i == MSB) begin : g_top
      alu_msb_slice u_s (
        .a_i(a_i[i]), .b_i(b_i[i]), .binv_i(sub_w), .carry_i(c_in),
        .less_i(lss), .sel_i(sel_w), .res_o(r), .carry_o(c_out),
        .set_o(set_w), .ovf_o(ovf_raw)
      );
    end else begin : g_low
      alu_bit_slice u_s (
        .a_i(a_i[i]), .b_i(b_i[i]), .binv_i(sub_w), .carry_i(c_in),
        .less_i(lss), .sel_i(sel_w), .res_o(r), .carry_o(c_out)
      );
    end
    assign slice_res[i] = r;
  end

  alu_shift_unit #(.W(W)) u_sh (.a_i(a_i), .asr_o(asr_w), .rol_o(rol_w));

  always_comb begin
    case (op)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT: result_o = slice_res;
      OP_ASR:  result_o = asr_w;
      OP_ROL:  result_o = rol_w;
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;
  assign ovf_o  = ovf_raw & arith_w;

  always_comb begin
    // R10
    no_overflow_chk: assert (arith_w || !ovf_o)
      else $error("overflow on non-arithmetic code");
    // R5
    slt_upper_chk: assert (op != OP_SLT || result_o[W-1:1] == '0)
      else $error("compare result has upper bits set");
    // R6
    asr_sign_chk: assert (op != OP_ASR || result_o[MSB] == a_i[MSB])
      else $error("shift lost sign bit");
    // R7
    rol_wrap_chk: assert (op != OP_ROL || result_o[0] == a_i[MSB])
      else $error("rotate lost top bit");
    // R9
    zero_flag_chk: assert (!zero_o || result_o == '0)
      else $error("zero flag with nonzero result");
  end
endmodule

// File: tb/sim_alu_sliced.sv
module sim_alu_sliced;
  localparam int W = 4;

  typedef struct {
    logic [2:0]   op;
    logic [W-1:0] a, b, res;
    logic         zero, ovf;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic [2:0]   op;
  logic [W-1:0] result;
  logic         zero, ovf;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  item_t q[$];

  always #5 clk = ~clk;

  alu_sliced #(.W(W)) u0 (.a_i(a), .b_i(b), .op_i(op), .result_o(result),
                          .zero_o(zero), .ovf_o(ovf));

  function automatic item_t model(logic [2:0] o, logic [W-1:0] x, logic [W-1:0] y);
    item_t it;
    int sx, sy, s;
    sx = $signed(x); sy = $signed(y);
    it.op = o; it.a = x; it.b = y; it.ovf = 1'b0;
    case (o)
      3'b000: it.res = x & y;
      3'b001: it.res = x | y;
      3'b010: begin s = sx + sy; it.res = x + y; it.ovf = (s > 7) || (s < -8); end
      3'b110: begin s = sx - sy; it.res = x - y; it.ovf = (s > 7) || (s < -8); end
      3'b111: it.res = (sx < sy) ? 4'd1 : 4'd0;
      3'b011: it.res = {x[3], x[3:1]};
      3'b100: it.res = {x[2:0], x[3]};
      default: it.res = 4'd0;
    endcase
    it.zero = (it.res == 4'd0);
    return it;
  endfunction

  function automatic string op_tag(logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      3'b011: return "R6";
      3'b100: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic drive(logic [2:0] o, logic [W-1:0] x, logic [W-1:0] y);
    @(posedge clk);
    #1;
    q.push_back(model(o, x, y));
    a = x; b = y; op = o;
  endtask

  // monitor: compare half a cycle after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        n_chk++;
        if (result !== e.res) begin
          n_bad++;
          $display("FAIL %s op=%b a=%b b=%b result act=%b exp=%b", op_tag(e.op), e.op, e.a, e.b, result, e.res);
        end
        n_chk++;
        if (zero !== e.zero) begin
          n_bad++;
          $display("FAIL R9 op=%b a=%b b=%b zero act=%b exp=%b", e.op, e.a, e.b, zero, e.zero);
        end
        n_chk++;
        if (ovf !== e.ovf) begin
          n_bad++;
          $display("FAIL R10 op=%b a=%b b=%b ovf act=%b exp=%b", e.op, e.a, e.b, ovf, e.ovf);
        end
      end
    end
  end

  initial begin
    a = '0; b = '0; op = 3'b000;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // initial state: all-zero inputs give zero result, R9
    drive(3'b000, 4'd0, 4'd0);
    drive(3'b010, 4'd7, 4'd1);     // R3 R10: 7+1 overflows
    drive(3'b110, 4'd8, 4'd1);     // R4 R10: -8-1 overflows
    drive(3'b111, 4'd8, 4'd7);     // R5: -8 < 7
    drive(3'b111, 4'd7, 4'd8);     // R5: 7 not < -8
    drive(3'b110, 4'd5, 4'd5);     // R4 R9: zero result
    drive(3'b010, 4'd8, 4'd8);     // R3 R10: -8+-8 wraps to 0
    drive(3'b011, 4'b1010, 4'hF);  // R6: b ignored
    drive(3'b100, 4'b1001, 4'h5);  // R7: b ignored
    drive(3'b101, 4'hF, 4'hF);     // R8
    drive(3'b000, 4'b1100, 4'b1010); // R1
    drive(3'b001, 4'b1100, 4'b1010); // R2
    for (int o = 0; o < 8; o++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          drive(o[2:0], x[3:0], y[3:0]);
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=%0d exp=done", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule